// File: doc/BRIEF.md
# Sustained-Condition Trigger Counter

This block is the trigger stage of an on-chip debug probe. It watches a 23-bit probe port and a single probe pin. On every clock edge while armed, it checks whether a qualifying condition holds: the port is at or above a programmable limit, or the pin is low. A 16-bit counter measures how many consecutive cycles the condition has held. Any break in the condition sends the counter back to zero.

When the count equals a programmable target, the block clears the counter and raises a registered trigger pulse for one cycle. It stays armed and starts counting again. A condition held without a break therefore fires once every target+1 cycles. The target and the limit are copied from configuration inputs on every disarmed edge. They are frozen while the unit is armed.

Top module: `sustain_trigger`

## Requirements
- R1: A synchronous active-high reset clears the count and the trigger and restores the target to 2000 and the limit to 456. These defaults apply if arm is already high when reset is released.
- R2: The condition is (probe_port >= limit, an unsigned 23-bit compare) OR (probe_pin == 0). A port value equal to the limit qualifies, and a value one below it does not.
- R3: On an armed edge where count differs from the target and the condition holds, the count goes up by one.
- R4: On an armed edge where count differs from the target and the condition fails, the count returns to 0 and no trigger is raised.
- R5: On an armed edge where count equals the target, the count becomes 0 and trig is high for the following cycle, whatever the condition is on that edge.
- R6: With the target at 1 or more and the condition held, trig is one cycle wide. The first pulse follows target+1 armed edges, and later pulses repeat every target+1 cycles.
- R7: While arm is low, the count is held at 0 and trig stays low. Dropping arm on the edge where the count matches the target suppresses the trigger.
- R8: The target and limit are sampled from cfg_target and cfg_limit on every disarmed edge. Changes made while armed have no effect until arm has been low for at least one edge.
- R9: With a target of 0, every armed edge produces a trigger, whatever the condition is.
- R10: The count never exceeds the target. A target of 65535 is reached without wrapping and then triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Enables evaluation; low holds the count at zero and loads the configuration |
| probe_port | input | 23 | Observed multi-bit value |
| probe_pin | input | 1 | Observed single-bit value; low qualifies |
| cfg_target | input | 16 | Target count, loaded while disarmed |
| cfg_limit | input | 23 | Port limit, loaded while disarmed |
| trig | output | 1 | Registered one-cycle trigger pulse |
| count | output | 16 | Current consecutive-cycle count |

## Verification
Two events can fall on the same edge: the target match and a break in the condition. The bench holds the condition until the count reaches the target, then removes it for exactly the matching edge. It then expects a trigger with the count at zero, which shows that the compare takes precedence over the clear path. The bench also drops arm on the matching edge and expects no pulse. It confirms that the count and the trigger stay at zero while disarmed.

// File: rtl/sustain_trigger.sv
module sustain_trigger #(
  parameter int CNT_W      = 16,
  parameter int PORT_W     = 23,
  parameter int DEF_TARGET = 2000,
  parameter int DEF_LIMIT  = 456
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [PORT_W-1:0] probe_port,
  input  logic              probe_pin,
  input  logic [CNT_W-1:0]  cfg_target,
  input  logic [PORT_W-1:0] cfg_limit,
  output logic              trig,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0]  cnt_q, target_q;
  logic [PORT_W-1:0] limit_q;
  logic              trig_q;

  wire hit  = (cnt_q == target_q);
  wire qual = (probe_port >= limit_q) || !probe_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      trig_q   <= 1'b0;
      target_q <= CNT_W'(DEF_TARGET);
      limit_q  <= PORT_W'(DEF_LIMIT);
    end else if (!arm) begin
      cnt_q    <= '0;
      trig_q   <= 1'b0;
      target_q <= cfg_target;
      limit_q  <= cfg_limit;
    end else begin
      trig_q <= hit;
      if (hit)       cnt_q <= '0;
      else if (qual) cnt_q <= cnt_q + 1'b1;
      else           cnt_q <= '0;
    end
  end

  assign trig  = trig_q;
  assign count = cnt_q;

  a_r10_count_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= target_q);

  a_r5_pulse_with_zero: assert property (@(posedge clk) disable iff (rst)
    trig |-> count == '0);

  a_r7_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (count == '0 && !trig));

  a_r4_break_clears: assert property (@(posedge clk) disable iff (rst)
    (arm && count != target_q && probe_port < limit_q && probe_pin) |=> (count == '0 && !trig));

  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (arm && count != target_q && (probe_port >= limit_q || !probe_pin)) |=> count == $past(count) + 1'b1);

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    arm |=> (target_q == $past(target_q) && limit_q == $past(limit_q)));

endmodule

// File: tb/sustain_trigger_tb.sv
module sustain_trigger_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [22:0] probe_port = '0;
  logic        probe_pin = 1'b1;
  logic [15:0] cfg_target = '0;
  logic [22:0] cfg_limit = '0;
  logic        trig;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sustain_trigger u_dut (
    .clk(clk), .rst(rst), .arm(arm), .probe_port(probe_port), .probe_pin(probe_pin),
    .cfg_target(cfg_target), .cfg_limit(cfg_limit), .trig(trig), .count(count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int tgt, input int lim);
    arm = 1'b0;
    cfg_target = 16'(tgt);
    cfg_limit = 23'(lim);
    tick();
    arm = 1'b1;
  endtask

  task automatic t_reset_defaults;
    rst = 1'b1; arm = 1'b1; cfg_target = 16'd5; cfg_limit = 23'd10;
    tick(); tick();
    chk("R1 trig after reset", trig, 0);
    chk("R1 count after reset", count, 0);
    rst = 1'b0; probe_pin = 1'b1; probe_port = 23'd456;
    tick();
    chk("R1 R2 default limit equal qualifies", count, 1);
    probe_port = 23'd455;
    tick();
    chk("R1 R2 below default limit clears", count, 0);
    probe_port = 23'd456;
    for (int i = 0; i < 2000; i++) tick();
    chk("R1 count at default target", count, 2000);
    chk("R1 no trig before match edge", trig, 0);
    tick();
    chk("R1 trig at default target", trig, 1);
    chk("R1 count cleared at trigger", count, 0);
  endtask

  task automatic t_condition;
    setup(10, 100);
    probe_port = 23'd99; probe_pin = 1'b0; tick();
    chk("R2 R3 pin low qualifies", count, 1);
    probe_port = 23'd100; probe_pin = 1'b1; tick();
    chk("R2 R3 port equal limit qualifies", count, 2);
    probe_port = 23'h7FFFFF; tick();
    chk("R2 R3 port max qualifies", count, 3);
    probe_port = 23'd99; tick();
    chk("R4 break clears count", count, 0);
    chk("R4 break no trig", trig, 0);
  endtask

  task automatic t_period;
    setup(3, 100);
    probe_port = 23'd200; probe_pin = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      chk("R6 periodic count", count, i % 4);
      chk("R6 periodic trig", trig, (i % 4 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_compare_first;
    setup(3, 100);
    probe_port = 23'd200; probe_pin = 1'b1;
    tick(); tick(); tick();
    chk("R5 count reached target", count, 3);
    probe_port = 23'd0;
    tick();
    chk("R5 trig despite break", trig, 1);
    chk("R5 count zero after match", count, 0);
    tick();
    chk("R5 trig one cycle", trig, 0);
  endtask

  task automatic t_disarm_at_match;
    setup(3, 100);
    probe_port = 23'd200; probe_pin = 1'b0;
    tick(); tick(); tick();
    arm = 1'b0;
    tick();
    chk("R7 disarm at match no trig", trig, 0);
    chk("R7 disarm count zero", count, 0);
    tick(); tick();
    chk("R7 disarmed count held", count, 0);
    chk("R7 disarmed trig low", trig, 0);
  endtask

  task automatic t_cfg_hold;
    setup(3, 100);
    probe_port = 23'd200; probe_pin = 1'b1;
    tick();
    cfg_target = 16'd20; cfg_limit = 23'h7FFFFF;
    tick(); tick();
    chk("R8 old limit still used", count, 3);
    tick();
    chk("R8 old target still used", trig, 1);
    arm = 1'b0; tick(); arm = 1'b1;
    tick();
    chk("R8 new limit after rearm", count, 0);
  endtask

  task automatic t_target_zero;
    setup(0, 100);
    probe_port = 23'd0; probe_pin = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 zero target trig", trig, 1);
      chk("R9 zero target count", count, 0);
    end
  endtask

  task automatic t_full_width;
    setup(65535, 0);
    probe_port = 23'd0; probe_pin = 1'b1;
    for (int i = 0; i < 65535; i++) tick();
    chk("R10 full target reached", count, 65535);
    chk("R10 no trig before match", trig, 0);
    tick();
    chk("R10 trig at full target", trig, 1);
    chk("R10 count cleared", count, 0);
  endtask

  initial begin
    t_reset_defaults();
    t_condition();
    t_period();
    t_compare_first();
    t_disarm_at_match();
    t_cfg_hold();
    t_target_zero();
    t_full_width();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule